// File: doc/BRIEF.md
# UART Line Break and Idle Detector

This block sits beside one UART channel and watches both serial directions. On the receive side it re-times the raw RX line through a two-flop synchroniser, samples it once per bit at the centre of the bit cell using the 16x baud tick, and raises an idle flag once the line has read high for four full character times in a row. The length of a character is taken from the current frame format, so the idle window follows the format: 7 to 12 bit cells per character.

On the transmit side it passes the transmitter's serial data to the TX pin through one register. While the break control input is high, the pin is forced low whatever the transmitter sends. Software clears the idle flag with a one-cycle pulse on `idle_clear`. The flag also drops by itself when a low sample shows that a new character has started.

Top module: `uart_line_monitor`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `tx_pin` is 1 and `rx_idle` is 0.
- R2: From the clock edge after `break_ctl` goes high, `tx_pin` is 0 for as long as `break_ctl` stays high, whatever value `tx_serial` has.
- R3: With `break_ctl` low, `tx_pin` equals the value `tx_serial` had one clock earlier. After `break_ctl` is released, normal data appears at the very next edge.
- R4: One character is 1 start bit, plus 5 + `len_sel` data bits (`len_sel` 0 to 3 gives 5 to 8), plus 1 bit when `parity_en` is 1, plus 1 stop bit (2 stop bits when `two_stop` is 1). The idle threshold is 4 times this bit count, counted in consecutive high bit samples.
- R5: Bit samples are taken on every 16th baud tick, at phase 7 of the 0..15 phase count. When the threshold-th consecutive high sample is taken, `rx_idle` is 1 after that same edge.
- R6: `rx_line` passes through two synchroniser flops. A falling edge of the synchronised line resets the bit phase, so the next sample falls on the 8th tick after that edge, in the middle of the start bit.
- R7: A low bit sample resets the high-sample count to zero and clears `rx_idle`.
- R8: A pulse on `idle_clear` clears `rx_idle` at the next edge. The flag is not raised again while the line stays high; it needs a fresh run of high samples after a low sample.
- R9: If `idle_clear` is high at the edge where the threshold is reached, setting the flag takes priority and `rx_idle` becomes 1.
- R10: In cycles where `baud_tick` is low, neither the bit phase nor the idle count advances, so gaps in the tick stream delay detection by exactly the gap length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| len_sel | input | 2 | Data length select: data bits = 5 + len_sel |
| parity_en | input | 1 | A parity bit is present in each character |
| two_stop | input | 1 | Characters carry two stop bits |
| rx_line | input | 1 | Raw asynchronous receive line |
| tx_serial | input | 1 | Serial data from the transmitter |
| break_ctl | input | 1 | Break control: hold the TX pin low |
| idle_clear | input | 1 | Pulse that clears the idle flag |
| tx_pin | output | 1 | Registered TX line after the break override |
| rx_idle | output | 1 | Receive idle flag |

## Verification
Two idle-flag events can land on one edge: a software clear, and the sample that completes the high-sample count. The bench raises `idle_clear` exactly for the edge at which the threshold sample is taken. It computes that edge from the synchroniser latency, the phase realignment and the frame length. It expects the flag to read 1 afterwards, and then confirms that a later, separate clear does remove it. The counting itself is judged edge-exact for four frame formats, once with a gap in the baud ticks. A flag that rises one cycle early or late is reported.

// File: rtl/ulm_pkg.sv
// Package: shared constants and the frame-format type for the line monitor.
// Assumes a 16x oversampling tick and the character layout of a standard UART.
package ulm_pkg;

    localparam int TICKS_PER_BIT = 16;
    localparam int START_BITS    = 1;
    localparam int MIN_DATA_BITS = 5;
    localparam int MIN_STOP_BITS = 1;
    localparam int MAX_EXTRA     = 3 + 1 + 1;  // len_sel max + parity + extra stop
    localparam int MIN_CHAR_BITS = START_BITS + MIN_DATA_BITS + MIN_STOP_BITS;
    localparam int MAX_CHAR_BITS = MIN_CHAR_BITS + MAX_EXTRA;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       parity_en;
        logic       two_stop;
    } ulm_fmt_t;

endpackage

// File: rtl/ulm_rx_sync.sv
// Module: multi-stage synchroniser for the asynchronous RX line.
// Assumes the line idles high, so every stage resets to RST_VAL.
module ulm_rx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    // Purpose: shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/ulm_bit_sampler.sv
// Module: finds the middle of each bit cell from the 16x tick and emits one
// sample strobe per bit. The phase realigns on every falling edge of the
// synchronised line. Assumes rx_s is already synchronous to clk.
module ulm_bit_sampler #(
    parameter int TICKS = ulm_pkg::TICKS_PER_BIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    input  logic rx_s,
    output logic samp_stb,
    output logic samp_val,
    output logic rx_fall
);

    localparam int PW  = $clog2(TICKS);
    localparam int MID = TICKS / 2 - 1;

    logic [PW-1:0] phase_q;
    logic          rx_prev_q;

    assign rx_fall  = rx_prev_q && !rx_s;
    assign samp_stb = baud_tick && (phase_q == PW'(MID)) && !rx_fall;
    assign samp_val = rx_s;

    // Purpose: remember the previous line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_prev_q <= 1'b1;
        end else begin
            rx_prev_q <= rx_s;
        end
    end

    // Purpose: run the bit phase on ticks, restarting it at a falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (rx_fall) begin
            phase_q <= '0;
        end else if (baud_tick) begin
            phase_q <= phase_q + PW'(1);
        end
    end

endmodule

// File: rtl/ulm_idle_tracker.sv
// Module: counts consecutive high bit samples against a threshold of
// IDLE_CHARS character times and keeps the idle flag. Assumes one strobe per bit.
module ulm_idle_tracker
    import ulm_pkg::*;
#(
    parameter int IDLE_CHARS = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  ulm_fmt_t fmt,
    input  logic     samp_stb,
    input  logic     samp_val,
    input  logic     idle_clear,
    output logic     rx_idle
);

    localparam int CW = $clog2(IDLE_CHARS * MAX_CHAR_BITS + 1);

    logic [CW-1:0] char_bits;
    logic [CW-1:0] thresh;
    logic [CW-1:0] cnt_q;
    logic          hit;
    logic          low_samp;
    logic          flag_q;

    // Purpose: derive the character length and the idle threshold from the format.
    always_comb begin
        char_bits = CW'(MIN_CHAR_BITS) + CW'(fmt.len_sel)
                  + CW'(fmt.parity_en) + CW'(fmt.two_stop);
        thresh    = CW'(IDLE_CHARS) * char_bits;
    end

    assign low_samp = samp_stb && !samp_val;
    assign hit      = samp_stb && samp_val && (cnt_q == thresh - CW'(1));

    // Purpose: count high samples, restarting on a low one and saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (samp_stb) begin
            if (!samp_val) begin
                cnt_q <= '0;
            end else if (cnt_q < thresh) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // Purpose: set on the threshold sample (wins over clear), drop on low sample or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (low_samp || idle_clear) begin
            flag_q <= 1'b0;
        end
    end

    assign rx_idle = flag_q;

endmodule

// File: rtl/ulm_tx_gate.sv
// Module: registered TX output with a level break override.
// Assumes the line idles high, so the pin resets to 1.
module ulm_tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_serial,
    input  logic break_ctl,
    output logic tx_pin
);

    logic pin_q;

    // Purpose: hold the pin low during break, else pass the transmitter data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b1;
        end else if (break_ctl) begin
            pin_q <= 1'b0;
        end else begin
            pin_q <= tx_serial;
        end
    end

    assign tx_pin = pin_q;

endmodule

// File: rtl/uart_line_monitor.sv
// Module: top of the UART line break and idle detector. It ties the RX
// synchroniser, the bit sampler and the idle tracker together, and places the
// break gate on the TX path. Assumes baud_tick is a one-cycle 16x strobe.
module uart_line_monitor #(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_CHARS  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic [1:0] len_sel,
    input  logic       parity_en,
    input  logic       two_stop,
    input  logic       rx_line,
    input  logic       tx_serial,
    input  logic       break_ctl,
    input  logic       idle_clear,
    output logic       tx_pin,
    output logic       rx_idle
);
    import ulm_pkg::*;

    ulm_fmt_t fmt;
    logic     rx_s;
    logic     samp_stb;
    logic     samp_val;
    logic     rx_fall;

    assign fmt = '{len_sel: len_sel, parity_en: parity_en, two_stop: two_stop};

    ulm_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (rx_s)
    );

    ulm_bit_sampler #(.TICKS(TICKS_PER_BIT)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .baud_tick(baud_tick),
        .rx_s     (rx_s),
        .samp_stb (samp_stb),
        .samp_val (samp_val),
        .rx_fall  (rx_fall)
    );

    ulm_idle_tracker #(.IDLE_CHARS(IDLE_CHARS)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt       (fmt),
        .samp_stb  (samp_stb),
        .samp_val  (samp_val),
        .idle_clear(idle_clear),
        .rx_idle   (rx_idle)
    );

    ulm_tx_gate u_txg (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_serial(tx_serial),
        .break_ctl(break_ctl),
        .tx_pin   (tx_pin)
    );

endmodule

// File: rtl/ulm_checker.sv
// Module: property checker for uart_line_monitor, attached with bind.
module ulm_checker (
    input logic clk,
    input logic rst_n,
    input logic break_ctl,
    input logic tx_serial,
    input logic tx_pin,
    input logic idle_clear,
    input logic rx_idle,
    input logic samp_stb,
    input logic samp_val,
    input logic rx_fall
);

    // R2: break forces the pin low at the next edge
    p_break_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        break_ctl |=> !tx_pin);

    // R3: without break, the pin follows the transmitter one cycle later
    p_tx_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !break_ctl |=> (tx_pin == $past(tx_serial)));

    // R5: the flag only rises after a high sample
    p_rise_on_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_idle) |-> ($past(samp_stb) && $past(samp_val)));

    // R7 / R8: the flag only falls after a low sample or a software clear
    p_fall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_idle) |-> ($past(idle_clear) || ($past(samp_stb) && !$past(samp_val))));

    // R6: a falling edge restarts the phase, so no sample follows at once
    p_realign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fall |=> !samp_stb);

endmodule

bind uart_line_monitor ulm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .break_ctl (break_ctl),
    .tx_serial (tx_serial),
    .tx_pin    (tx_pin),
    .idle_clear(idle_clear),
    .rx_idle   (rx_idle),
    .samp_stb  (samp_stb),
    .samp_val  (samp_val),
    .rx_fall   (rx_fall)
);

// File: tb/uart_line_monitor_test.sv
module uart_line_monitor_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic [1:0] len_sel = 2'd0;
    logic       parity_en = 1'b0;
    logic       two_stop = 1'b0;
    logic       rx_line = 1'b1;
    logic       tx_serial = 1'b1;
    logic       break_ctl = 1'b0;
    logic       idle_clear = 1'b0;
    logic       tx_pin;
    logic       rx_idle;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    typedef struct {
        int    at;
        bit    is_tx;
        logic  exp;
        string tag;
    } item_t;

    item_t q[$];
    item_t cur;
    logic  act;

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    uart_line_monitor uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .len_sel(len_sel),
        .parity_en(parity_en), .two_stop(two_stop), .rx_line(rx_line),
        .tx_serial(tx_serial), .break_ctl(break_ctl), .idle_clear(idle_clear),
        .tx_pin(tx_pin), .rx_idle(rx_idle)
    );

    // Driver side: queue an expectation, kept in time order.
    task automatic push(input int at, input bit is_tx, input logic exp, input string tag);
        item_t it;
        int pos;
        it.at = at; it.is_tx = is_tx; it.exp = exp; it.tag = tag;
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].at > at) begin
                pos = i;
                break;
            end
        end
        q.insert(pos, it);
    endtask

    // Monitor: compare due expectations away from the active edge.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            cur = q.pop_front();
            act = cur.is_tx ? tx_pin : rx_idle;
            checks++;
            if (cur.at != cyc || act !== cur.exp) begin
                fails++;
                $display("FAIL %s: %s actual=%b expected=%b (cycle %0d, due %0d)",
                         cur.tag, cur.is_tx ? "tx_pin" : "rx_idle", act, cur.exp, cyc, cur.at);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) step();
    endtask

    // Drop the line for one bit, release it, and expect idle after 4 characters.
    task automatic idle_run(input logic [1:0] ls, input logic par, input logic two,
                            input int char_bits, input bit prev_set, input int hole,
                            input bit coinc, input string tag);
        int t0;
        int t_set;
        len_sel = ls; parity_en = par; two_stop = two;
        t0 = cyc;
        rx_line = 1'b0;
        if (prev_set) push(t0 + 10, 0, 1'b1, "R7 flag still set before start sample");
        push(t0 + 11, 0, 1'b0, "R7 low sample clears flag");
        t_set = t0 + 11 + 16 * 4 * char_bits + hole;
        push(t_set - 1, 0, 1'b0, {tag, " one cycle before threshold"});
        push(t_set, 0, 1'b1, coinc ? "R9 set wins over clear" : {tag, " at threshold"});
        wait_to(t0 + 16);
        rx_line = 1'b1;
        if (hole > 0) begin
            wait_to(t0 + 20);
            baud_tick = 1'b0;
            wait_to(t0 + 20 + hole);
            baud_tick = 1'b1;
        end
        if (coinc) begin
            wait_to(t_set - 1);
            idle_clear = 1'b1;
            step();
            idle_clear = 1'b0;
        end
        wait_to(t_set + 1);
    endtask

    task automatic pulse_clear(input string tag);
        int c;
        c = cyc;
        idle_clear = 1'b1;
        push(c + 1, 0, 1'b0, tag);
        push(c + 150, 0, 1'b0, "R8 no re-raise while line stays high");
        step();
        idle_clear = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        push(cyc, 0, 1'b0, "R1 idle flag in reset");
        push(cyc, 1, 1'b1, "R1 tx pin in reset");
        step();
        rst_n = 1'b1;
        push(cyc, 0, 1'b0, "R1 idle flag after release");
        push(cyc, 1, 1'b1, "R1 tx pin after release");
        step();

        // Transmit path: follow, break override, release.
        tx_serial = 1'b0; push(cyc + 1, 1, 1'b0, "R3 follow 0"); step();
        tx_serial = 1'b1; push(cyc + 1, 1, 1'b1, "R3 follow 1"); step();
        break_ctl = 1'b1; push(cyc + 1, 1, 1'b0, "R2 break forces low"); step();
        tx_serial = 1'b0; push(cyc + 1, 1, 1'b0, "R2 break with data 0"); step();
        tx_serial = 1'b1; push(cyc + 1, 1, 1'b0, "R2 data 1 ignored in break"); step();
        break_ctl = 1'b0; push(cyc + 1, 1, 1'b1, "R3 release on next edge"); step();
        tx_serial = 1'b0; push(cyc + 1, 1, 1'b0, "R3 follow after release"); step();
        step();

        // 5 data bits, no parity, 1 stop: 7 bits per character.
        idle_run(2'd0, 1'b0, 1'b0, 7, 1'b0, 0, 1'b0, "R5 R4 7-bit frame");
        repeat (4) step();
        pulse_clear("R8 software clear");
        repeat (4) step();

        // 8 data bits, parity, 2 stop: 12 bits, clear in the threshold cycle.
        idle_run(2'd3, 1'b1, 1'b1, 12, 1'b0, 0, 1'b1, "R4 12-bit frame");
        repeat (4) step();
        push(cyc, 0, 1'b1, "R9 flag held after coincident clear");
        step();
        pulse_clear("R8 clear after coincidence");
        repeat (200) step();

        idle_run(2'd0, 1'b0, 1'b0, 7, 1'b0, 0, 1'b0, "R6 R5 realigned sampling");
        // 6 data bits, parity, 1 stop: 9 bits, with a 100-cycle tick gap.
        idle_run(2'd1, 1'b1, 1'b0, 9, 1'b1, 100, 1'b0, "R10 tick gap");
        // 7 data bits, no parity, 2 stop: 10 bits.
        idle_run(2'd2, 1'b0, 1'b1, 10, 1'b1, 0, 1'b0, "R4 10-bit frame");

        repeat (5) step();
        if (q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule